// File: doc/BRIEF.md
# User Interrupt Flag Control Unit

This block keeps the single enable flag that governs whether user-level interrupts may be taken. It executes three operations on that flag: clear, set and test. Each operation arrives as a one-cycle strobe with a 2-bit opcode. Alongside the strobe come the state bits that decide whether the operation is legal: the feature-enable control bit, a 64-bit-mode indicator, an enclave indicator, and an indicator that execution is inside a transactional region.

A legal clear or set changes the flag at the clock edge that samples the strobe. The new value is therefore visible on the very next cycle, which is the next instruction boundary. A test copies the flag into a carry bit and zeroes the five other arithmetic status bits. An illegal operation produces an invalid-opcode fault pulse. A clear or set issued inside a transactional region produces an abort pulse together with the abort code of the matching legacy interrupt-disable or interrupt-enable instruction. The abort itself is carried out elsewhere. All outputs are registered.

Top module: `uif_ctrl_unit`

## Requirements
- R1: A legal clear (opcode 2'b00) issued outside a transactional region drives `flag_o` to 0 on the cycle after the strobe.
- R2: A legal set (opcode 2'b01) issued outside a transactional region drives `flag_o` to 1 on the cycle after the strobe.
- R3: A legal test (opcode 2'b10) loads `status_o` on the cycle after the strobe, using the flag value held before the strobe.
  - Bit 0 is the carry bit, equal to that flag value.
  - Bits 1 to 5 (zero, auxiliary, overflow, parity, sign) are 0.
  - `test_res_o` equals the carry bit.
  - Both outputs hold their value until the next legal test.
- R4: An operation is legal only when all of the following are true: `feat_en_i`=1, `mode64_i`=1, `enclave_i`=0, and the opcode is not the reserved value 2'b11. Any strobed operation that is not legal gives `fault_o`=1 on the cycle after the strobe.
- R5: A legal clear or set with `txn_i`=1 gives `abort_o`=1 on the cycle after the strobe. `abort_code_o` is then CODE_CLR for a clear and CODE_SET for a set. At all other times `abort_code_o` is 0.
- R6: A legal test with `txn_i`=1 executes normally and raises no abort.
- R7: An operation that faults or aborts leaves `flag_o`, `status_o` and `test_res_o` unchanged.
- R8: While `rst` is high, `flag_o`, `status_o`, `test_res_o`, `fault_o`, `abort_o` and `abort_code_o` are all 0. They take these values after the first clock edge with `rst` high.
- R9: `fault_o` and `abort_o` are one-cycle pulses that occur only on the cycle after a strobe. When both conditions hold, only the fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 2 | 00 clear, 01 set, 10 test, 11 reserved |
| feat_en_i | input | 1 | Feature enable control bit |
| mode64_i | input | 1 | Processor in 64-bit mode |
| enclave_i | input | 1 | Execution inside an enclave |
| txn_i | input | 1 | Execution inside a transactional region |
| flag_o | output | 1 | User interrupt enable flag |
| status_o | output | 6 | Test status bits: {sign, parity, overflow, auxiliary, zero, carry} |
| test_res_o | output | 1 | Test result, equal to the carry bit |
| fault_o | output | 1 | Invalid-opcode fault pulse |
| abort_o | output | 1 | Transactional abort request pulse |
| abort_code_o | output | ABORT_W | Abort code, valid while `abort_o` is high |

## Verification
The fault check and the transactional abort check can both be true for the same strobe. This happens for a clear or set with `txn_i` high while any gating input is wrong. The bench provokes it by sweeping every combination of opcode, the four gating inputs and the starting flag value. In each of those cycles it expects `fault_o` high, `abort_o` low, `abort_code_o` zero and the flag unchanged. A bound property also requires that the two pulses are never high together.

// File: rtl/uif_pkg.sv
package uif_pkg;
  typedef enum logic [1:0] {
    UOP_CLR  = 2'd0,
    UOP_SET  = 2'd1,
    UOP_TEST = 2'd2,
    UOP_RSVD = 2'd3
  } uop_e;

  localparam int STATUS_W = 6;
  localparam int ST_CF    = 0;
  localparam int ST_ZF    = 1;
  localparam int ST_AF    = 2;
  localparam int ST_OF    = 3;
  localparam int ST_PF    = 4;
  localparam int ST_SF    = 5;
endpackage

// File: rtl/uif_gate.sv
module uif_gate
  import uif_pkg::*;
(
  input  logic       op_valid_i,
  input  logic [1:0] op_code_i,
  input  logic       feat_en_i,
  input  logic       mode64_i,
  input  logic       enclave_i,
  input  logic       txn_i,
  output logic       fault_req_o,
  output logic       abort_req_o,
  output logic       abort_is_set_o,
  output logic       clr_ok_o,
  output logic       set_ok_o,
  output logic       test_ok_o
);
  logic perm_ok;
  logic op_known;
  logic legal;
  logic is_clr;
  logic is_set;
  logic is_test;

  always_comb begin
    is_clr  = (op_code_i == UOP_CLR);
    is_set  = (op_code_i == UOP_SET);
    is_test = (op_code_i == UOP_TEST);
    op_known = is_clr | is_set | is_test;
    perm_ok  = feat_en_i & mode64_i & ~enclave_i;
    legal    = perm_ok & op_known;
    // fault outranks abort
    fault_req_o    = op_valid_i & ~legal;
    abort_req_o    = op_valid_i & legal & txn_i & (is_clr | is_set);
    abort_is_set_o = is_set;
    clr_ok_o       = op_valid_i & legal & ~txn_i & is_clr;
    set_ok_o       = op_valid_i & legal & ~txn_i & is_set;
    test_ok_o      = op_valid_i & legal & is_test;
  end
endmodule

// File: rtl/uif_flag_reg.sv
module uif_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic clr_ok_i,
  input  logic set_ok_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)           flag_o <= 1'b0;
    else if (set_ok_i) flag_o <= 1'b1;
    else if (clr_ok_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uif_status_gen.sv
module uif_status_gen
  import uif_pkg::*;
#(
  parameter int SW    = STATUS_W,
  parameter int CF_IX = ST_CF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_ok_i,
  input  logic          flag_i,
  output logic [SW-1:0] status_o,
  output logic          res_o
);
  logic [SW-1:0] next_status;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    if (b == CF_IX) begin : g_carry
      assign next_status[b] = flag_i;
    end else begin : g_zero
      assign next_status[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      res_o    <= 1'b0;
    end else if (test_ok_i) begin
      status_o <= next_status;
      res_o    <= next_status[CF_IX];
    end
  end
endmodule

// File: rtl/uif_ctrl_unit.sv
module uif_ctrl_unit
  import uif_pkg::*;
#(
  parameter int               ABORT_W  = 8,
  parameter logic [ABORT_W-1:0] CODE_CLR = 8'h0A,
  parameter logic [ABORT_W-1:0] CODE_SET = 8'h0B
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid_i,
  input  logic [1:0]          op_code_i,
  input  logic                feat_en_i,
  input  logic                mode64_i,
  input  logic                enclave_i,
  input  logic                txn_i,
  output logic                flag_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                test_res_o,
  output logic                fault_o,
  output logic                abort_o,
  output logic [ABORT_W-1:0]  abort_code_o
);
  logic fault_req, abort_req, abort_is_set;
  logic clr_ok, set_ok, test_ok;

  uif_gate u_gate (
    .op_valid_i     (op_valid_i),
    .op_code_i      (op_code_i),
    .feat_en_i      (feat_en_i),
    .mode64_i       (mode64_i),
    .enclave_i      (enclave_i),
    .txn_i          (txn_i),
    .fault_req_o    (fault_req),
    .abort_req_o    (abort_req),
    .abort_is_set_o (abort_is_set),
    .clr_ok_o       (clr_ok),
    .set_ok_o       (set_ok),
    .test_ok_o      (test_ok)
  );

  uif_flag_reg u_flag (
    .clk      (clk),
    .rst      (rst),
    .clr_ok_i (clr_ok),
    .set_ok_i (set_ok),
    .flag_o   (flag_o)
  );

  uif_status_gen #(.SW(STATUS_W), .CF_IX(ST_CF)) u_status (
    .clk       (clk),
    .rst       (rst),
    .test_ok_i (test_ok),
    .flag_i    (flag_o),
    .status_o  (status_o),
    .res_o     (test_res_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o      <= 1'b0;
      abort_o      <= 1'b0;
      abort_code_o <= '0;
    end else begin
      fault_o      <= fault_req;
      abort_o      <= abort_req;
      abort_code_o <= abort_req ? (abort_is_set ? CODE_SET : CODE_CLR) : '0;
    end
  end
endmodule

// File: rtl/uif_ctrl_chk.sv
module uif_ctrl_chk
  import uif_pkg::*;
#(
  parameter int               ABORT_W  = 8,
  parameter logic [ABORT_W-1:0] CODE_CLR = 8'h0A,
  parameter logic [ABORT_W-1:0] CODE_SET = 8'h0B
) (
  input logic                clk,
  input logic                rst,
  input logic                op_valid_i,
  input logic [1:0]          op_code_i,
  input logic                feat_en_i,
  input logic                mode64_i,
  input logic                enclave_i,
  input logic                txn_i,
  input logic                flag_o,
  input logic [STATUS_W-1:0] status_o,
  input logic                test_res_o,
  input logic                fault_o,
  input logic                abort_o,
  input logic [ABORT_W-1:0]  abort_code_o
);
  logic perm;
  assign perm = feat_en_i & mode64_i & ~enclave_i;

  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && perm && !txn_i && op_code_i == UOP_CLR) |=> !flag_o); // R1
  AST_SET_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && perm && !txn_i && op_code_i == UOP_SET) |=> flag_o); // R2
  AST_TEST_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && perm && op_code_i == UOP_TEST) |=>
      (status_o[ST_CF] == $past(flag_o)) && (test_res_o == $past(flag_o)) && (status_o[STATUS_W-1:1] == '0)); // R3
  AST_GATE_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !perm) |=> fault_o); // R4
  AST_ABORT_CODE: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (abort_code_o == CODE_CLR || abort_code_o == CODE_SET)); // R5
  AST_TEST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == UOP_TEST) |=> !abort_o); // R6
  AST_FAULT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> flag_o == $past(flag_o)); // R7
  AST_ABORT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> flag_o == $past(flag_o)); // R7
  AST_FAULT_OVER_ABORT: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && abort_o)); // R9
  AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i |=> (!fault_o && !abort_o)); // R9
endmodule

bind uif_ctrl_unit uif_ctrl_chk #(
  .ABORT_W(ABORT_W), .CODE_CLR(CODE_CLR), .CODE_SET(CODE_SET)
) u_chk (
  .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
  .feat_en_i(feat_en_i), .mode64_i(mode64_i), .enclave_i(enclave_i),
  .txn_i(txn_i), .flag_o(flag_o), .status_o(status_o),
  .test_res_o(test_res_o), .fault_o(fault_o), .abort_o(abort_o),
  .abort_code_o(abort_code_o)
);

// File: tb/uif_ctrl_unit_tb.sv
module uif_ctrl_unit_tb;
  localparam int ABORT_W = 8;
  localparam logic [7:0] C_CLR = 8'h0A;
  localparam logic [7:0] C_SET = 8'h0B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic feat = 1'b0, m64 = 1'b0, encl = 1'b0, txn = 1'b0;
  logic flag, test_res, fault, abrt;
  logic [5:0] status;
  logic [7:0] code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic m_flag = 1'b0;
  logic [5:0] m_status = '0;

  always #2.5 clk = ~clk;

  uif_ctrl_unit #(.ABORT_W(ABORT_W), .CODE_CLR(C_CLR), .CODE_SET(C_SET)) u_dut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid), .op_code_i(op_code),
    .feat_en_i(feat), .mode64_i(m64), .enclave_i(encl), .txn_i(txn),
    .flag_o(flag), .status_o(status), .test_res_o(test_res),
    .fault_o(fault), .abort_o(abrt), .abort_code_o(code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one strobe at a falling edge; outputs are sampled at the next falling edge
  task automatic do_op(input logic [1:0] op, input logic fe, input logic mm, input logic en, input logic tx);
    op_valid = 1'b1; op_code = op; feat = fe; m64 = mm; encl = en; txn = tx;
    @(negedge clk);
    op_valid = 1'b0; op_code = 2'd0; feat = 1'b0; m64 = 1'b0; encl = 1'b0; txn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "flag", flag, 0);
    chk("R8", "status", status, 0);
    chk("R8", "test_res", test_res, 0);
    chk("R8", "fault", fault, 0);
    chk("R8", "abort", abrt, 0);
    chk("R8", "code", code, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int init = 0; init < 2; init++) begin
      for (int c = 0; c < 64; c++) begin
        logic [1:0] op;
        logic fe, mm, en, tx, legal, e_fault, e_abort;
        logic [7:0] e_code;
        op = c[1:0]; fe = c[2]; mm = c[3]; en = c[4]; tx = c[5];
        // preset the flag with a legal operation
        do_op(init[0] ? 2'd1 : 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        m_flag = init[0];
        chk(init[0] ? "R2" : "R1", "preset flag", flag, m_flag);

        legal   = fe & mm & ~en & (op != 2'd3);
        e_fault = ~legal;
        e_abort = legal & tx & (op != 2'd2);
        e_code  = e_abort ? ((op == 2'd1) ? C_SET : C_CLR) : 8'h00;
        if (legal && op == 2'd2) m_status = {5'b0, m_flag};
        if (legal && !tx && op == 2'd0) m_flag = 1'b0;
        if (legal && !tx && op == 2'd1) m_flag = 1'b1;

        do_op(op, fe, mm, en, tx);
        chk(e_fault ? "R4" : "R4/R9", "fault", fault, e_fault);
        chk(tx && !e_abort && op != 2'd2 ? "R9" : (op == 2'd2 ? "R6" : "R5"), "abort", abrt, e_abort);
        chk("R5", "abort code", code, e_code);
        chk((e_fault || e_abort) ? "R7" : "R1/R2", "flag", flag, m_flag);
        chk("R3", "status", status, m_status);
        chk("R3", "test result", test_res, m_status[0]);
        @(negedge clk);
        chk("R9", "fault pulse width", fault, 0);
        chk("R9", "abort pulse width", abrt, 0);
        chk("R5", "idle code", code, 0);
      end
    end

    // back-to-back test strobes observe the flag changed in between (R3, R1, R2)
    do_op(2'd1, 1, 1, 0, 0);
    do_op(2'd2, 1, 1, 0, 1);
    chk("R3", "carry after set", status, 6'b000001);
    chk("R6", "no abort on test", abrt, 0);
    do_op(2'd0, 1, 1, 0, 0);
    chk("R1", "flag after clear", flag, 0);
    chk("R3", "status holds", status, 6'b000001);
    do_op(2'd2, 1, 1, 0, 0);
    chk("R3", "carry after clear", status, 6'b000000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule